// File: doc/BRIEF.md
# Frame Status Queue for Bit-Oriented Link Receivers

This block sits beside the receive path of an HDLC/SDLC link controller. It counts the bytes of each received frame. When a frame closes on its ending flag, or is cut short by an abort, it stores the byte count and a small set of per-frame status bits in a first-in first-out store. A DMA engine can then keep moving payload bytes into memory while the CPU checks each frame's length and integrity later, one frame at a time.

Software reads three byte-wide views: count low, count high with flags, and status. Only the status read retires the oldest entry. The queue works only when its enable bit is set and bit-oriented mode is selected. In every other case the three views pass through live status and two images of other registers, and no frames are recorded. The status view also falls back to live status while the queue is empty. Status bits that are not stored always come straight from live status.

Top module: `hdlc_frame_stat`

## Requirements
- R1: The byte counter rises by one on each cycle with `byte_stb` high, stops at 16383 instead of wrapping, and a frame of more than 16383 bytes is stored with count 16383.
- R2: On `eof_stb` the current count is pushed together with `end_stat`, and the counter restarts at 0 for the next frame. A `byte_stb` in the same cycle counts toward the frame that is closing.
- R3: On `abort_stb` the count and `end_stat` are pushed and the counter restarts, exactly as for an ending flag.
- R4: The queue is active only when the enable register is 1 and `hdlc_mode` is 1. The enable register clears on reset and loads `cfg_en` when `cfg_we` is high. While inactive, `stat_q` equals `live_stat`, `cnt_lo_q` equals `alt_lo`, and `cnt_hi_q` equals `alt_hi`. While inactive, frame ends push nothing and status reads pop nothing, and entries already held are kept.
- R5: While active, `cnt_hi_q` carries bit 7 = overflow, bit 6 = entry available and bits 5..0 = count bits 13..8 of the oldest entry. `cnt_lo_q` carries count bits 7..0. Both count fields read 0 while the queue is empty.
- R6: `end_stat` bits are [2:0] residue, [3] overrun and [4] CRC error. When active and non-empty, `stat_q` reads bit 7 = 1 (end of frame), bit 6 = stored CRC error, bit 5 = stored overrun, bit 4 = `live_stat[4]` (parity), bits 3..1 = stored residue and bit 0 = `live_stat[0]` (all sent). When active and empty, `stat_q` equals `live_stat`.
- R7: Reads of the count views (`rd_lo`, `rd_hi`) never remove an entry. Only `rd_stat` does.
- R8: The store holds 10 entries. A frame end that arrives with 10 entries held is dropped and sets the overflow flag, unless a status read pops in the same cycle, in which case the frame is stored.
- R9: A status read on an empty queue changes nothing. The overflow flag stays set until `clr_ovf` is pulsed.
- R10: Entries come out in the order the frames ended, across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the enable register |
| cfg_en | input | 1 | Value loaded into the enable register |
| hdlc_mode | input | 1 | Bit-oriented framing mode selected |
| byte_stb | input | 1 | One received byte in this cycle |
| eof_stb | input | 1 | Frame closed by its ending flag |
| abort_stb | input | 1 | Frame ended by abort |
| end_stat | input | 5 | Per-frame status: residue[2:0], overrun, CRC error |
| live_stat | input | 8 | Live receive status byte |
| alt_lo | input | 8 | Image returned by the low count view in bypass |
| alt_hi | input | 8 | Image returned by the high count view in bypass |
| clr_ovf | input | 1 | Clears the sticky overflow flag |
| rd_lo | input | 1 | Read strobe, count low view |
| rd_hi | input | 1 | Read strobe, count high view |
| rd_stat | input | 1 | Read strobe, status view; pops an entry |
| cnt_lo_q | output | 8 | Count low view |
| cnt_hi_q | output | 8 | Count high view with flags |
| stat_q | output | 8 | Status view |

## Verification
The bench uses the default values, DEPTH = 10 and CNT_W = 14. This makes overflow reachable with eleven back-to-back frames, and makes the counter ceiling reachable with a frame of a little over 16 k bytes in well under the run limit. Because the depth is not a power of two, filling and draining the queue after earlier pops drives both pointers through their non-binary wrap. The full-queue case where a pop and a push land in the same cycle is also exercised at this depth.

// File: rtl/hdlc_frame_stat.sv
module hdlc_frame_stat #(
  parameter int DEPTH = 10,
  parameter int CNT_W = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_en,
  input  logic       hdlc_mode,
  input  logic       byte_stb,
  input  logic       eof_stb,
  input  logic       abort_stb,
  input  logic [4:0] end_stat,
  input  logic [7:0] live_stat,
  input  logic [7:0] alt_lo,
  input  logic [7:0] alt_hi,
  input  logic       clr_ovf,
  input  logic       rd_lo,
  input  logic       rd_hi,
  input  logic       rd_stat,
  output logic [7:0] cnt_lo_q,
  output logic [7:0] cnt_hi_q,
  output logic [7:0] stat_q
);
  localparam int ENT_W = CNT_W + 5;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             en_q;
  logic [CNT_W-1:0] bcnt;
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level;
  logic             ovf;

  wire active    = en_q & hdlc_mode;
  wire frame_end = eof_stb | abort_stb;
  wire empty     = (level == '0);
  wire full      = (level == LVL_W'(DEPTH));
  wire pop       = active & rd_stat & ~empty;
  wire push_req  = active & frame_end;
  wire push      = push_req & (~full | pop);
  wire count_vw  = rd_lo | rd_hi;

  wire [CNT_W-1:0] bcnt_inc = (byte_stb && bcnt != CNT_MAX) ? bcnt + 1'b1 : bcnt;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= 1'b0;
    else if (cfg_we) en_q <= cfg_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else bcnt <= frame_end ? '0 : bcnt_inc;

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= {bcnt_inc, end_stat};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      level <= level + LVL_W'(push) - LVL_W'(pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovf <= 1'b0;
    else if (push_req && !push) ovf <= 1'b1;
    else if (clr_ovf) ovf <= 1'b0;

  wire [ENT_W-1:0] head   = mem[rd_ptr];
  wire [13:0]      head_c = 14'(head[ENT_W-1:5]);
  wire [4:0]       head_s = head[4:0];
  wire             show   = active & ~empty;

  assign cnt_lo_q = !active ? alt_lo : (show ? head_c[7:0] : 8'h00);
  assign cnt_hi_q = !active ? alt_hi : {ovf, ~empty, show ? head_c[13:8] : 6'h00};
  assign stat_q   = !show ? live_stat :
                    {1'b1, head_s[4], head_s[3], live_stat[4], head_s[2:0], live_stat[0]};

  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)) else $error("level above depth"); // R8
  AST_CNT_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt == CNT_MAX && !frame_end) |=> bcnt == CNT_MAX) else $error("counter wrapped"); // R1
  AST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> bcnt == '0) else $error("counter not restarted"); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_ovf) |=> ovf) else $error("overflow lost"); // R9
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && empty && !frame_end) |=> level == '0) else $error("empty pop moved level"); // R9
  AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(level)) else $error("bypass changed queue"); // R4
  AST_COUNT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (count_vw && !rd_stat && !frame_end) |=> $stable(level)) else $error("count read popped"); // R7
endmodule

// File: tb/test_hdlc_frame_stat.sv
`timescale 1ns/1ps
module test_hdlc_frame_stat;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_en = 0, hdlc_mode = 0;
  logic byte_stb = 0, eof_stb = 0, abort_stb = 0, clr_ovf = 0;
  logic rd_lo = 0, rd_hi = 0, rd_stat = 0;
  logic [4:0] end_stat = 0;
  logic [7:0] live_stat = 8'h7F, alt_lo = 8'hA5, alt_hi = 8'h3C;
  logic [7:0] cnt_lo_q, cnt_hi_q, stat_q;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  hdlc_frame_stat i_hdlc_frame_stat (
    .clk, .rst_n, .cfg_we, .cfg_en, .hdlc_mode, .byte_stb, .eof_stb, .abort_stb,
    .end_stat, .live_stat, .alt_lo, .alt_hi, .clr_ovf, .rd_lo, .rd_hi, .rd_stat,
    .cnt_lo_q, .cnt_hi_q, .stat_q);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [7:0] exp_stat(logic [4:0] s);
    return {1'b1, s[4], s[3], live_stat[4], s[2:0], live_stat[0]};
  endfunction

  task automatic send_bytes(int n);
    if (n > 0) begin
      byte_stb = 1;
      repeat (n) step();
      byte_stb = 0;
    end
  endtask

  task automatic close_frame(bit ab, logic [4:0] s, bit with_byte);
    eof_stb = !ab; abort_stb = ab; end_stat = s; byte_stb = with_byte;
    step();
    eof_stb = 0; abort_stb = 0; byte_stb = 0;
  endtask

  task automatic read_entry(output logic [7:0] hi, output logic [7:0] lo, output logic [7:0] st);
    rd_hi = 1; #1 hi = cnt_hi_q; step(); rd_hi = 0;
    rd_lo = 1; #1 lo = cnt_lo_q; step(); rd_lo = 0;
    rd_stat = 1; #1 st = stat_q; step(); rd_stat = 0;
  endtask

  task automatic t_reset();
    hdlc_mode = 1;
    #1;
    check("R4 reset bypass stat", stat_q, live_stat);
    check("R4 reset bypass lo", cnt_lo_q, alt_lo);
    check("R4 reset bypass hi", cnt_hi_q, alt_hi);
    cfg_we = 1; cfg_en = 1; step(); cfg_we = 0;
    check("R5 empty hi", cnt_hi_q, 8'h00);
    check("R5 empty lo", cnt_lo_q, 8'h00);
    check("R6 empty stat live", stat_q, live_stat);
  endtask

  task automatic t_frames();
    logic [7:0] hi, lo, st;
    send_bytes(3); close_frame(0, 5'b10101, 0);
    close_frame(1, 5'b01010, 0);
    send_bytes(300); close_frame(0, 5'b00011, 1);
    check("R5 avail flag", cnt_hi_q, 8'h40);
    rd_hi = 1; step(); step(); rd_hi = 0; rd_lo = 1; step(); rd_lo = 0;
    check("R7 count reads keep head", cnt_lo_q, 8'd3);
    read_entry(hi, lo, st);
    check("R2 first count hi", hi, 8'h40);
    check("R2 first count lo", lo, 8'd3);
    check("R6 first status", st, exp_stat(5'b10101));
    read_entry(hi, lo, st);
    check("R3 abort count", {hi, lo}, 16'h4000);
    check("R3 abort status", st, exp_stat(5'b01010));
    read_entry(hi, lo, st);
    check("R2 same-cycle byte count", {hi, lo}, {8'h41, 8'h2D});
    check("R10 third status", st, exp_stat(5'b00011));
    check("R5 drained", cnt_hi_q, 8'h00);
  endtask

  task automatic t_overflow();
    logic [7:0] hi, lo, st;
    for (int i = 0; i < 11; i++) begin
      send_bytes(i + 1); close_frame(0, 5'(i), 0);
    end
    check("R8 overflow flag", cnt_hi_q, 8'hC0);
    for (int i = 0; i < 10; i++) begin
      read_entry(hi, lo, st);
      check("R10 order count", lo, 8'(i + 1));
      check("R10 order status", st, exp_stat(5'(i)));
    end
    check("R9 sticky after drain", cnt_hi_q, 8'h80);
    rd_stat = 1; step(); step(); rd_stat = 0;
    check("R9 empty pop stat", stat_q, live_stat);
    send_bytes(7); close_frame(0, 5'b11111, 0);
    read_entry(hi, lo, st);
    check("R9 after empty pop", lo, 8'd7);
    check("R9 still sticky", hi, 8'hC0);
    clr_ovf = 1; step(); clr_ovf = 0;
    check("R9 cleared", cnt_hi_q, 8'h00);
  endtask

  task automatic t_full_swap();
    logic [7:0] hi, lo, st;
    for (int i = 0; i < 10; i++) begin
      send_bytes(2); close_frame(0, 5'd1, 0);
    end
    send_bytes(9);
    rd_stat = 1; close_frame(0, 5'd6, 0); rd_stat = 0;
    check("R8 swap no overflow", cnt_hi_q, 8'h40);
    for (int i = 0; i < 9; i++) read_entry(hi, lo, st);
    read_entry(hi, lo, st);
    check("R8 swap frame kept", lo, 8'd9);
    check("R8 swap status", st, exp_stat(5'd6));
    check("R8 now empty", cnt_hi_q, 8'h00);
  endtask

  task automatic t_bypass();
    logic [7:0] hi, lo, st;
    send_bytes(5); close_frame(0, 5'd2, 0);
    hdlc_mode = 0; #1;
    check("R4 bypass hi", cnt_hi_q, alt_hi);
    check("R4 bypass stat", stat_q, live_stat);
    send_bytes(4); close_frame(0, 5'd3, 0);
    rd_stat = 1; step(); rd_stat = 0;
    hdlc_mode = 1; #1;
    read_entry(hi, lo, st);
    check("R4 held entry kept", lo, 8'd5);
    check("R4 no bypass push", cnt_hi_q, 8'h00);
    cfg_we = 1; cfg_en = 0; step(); cfg_we = 0;
    check("R4 enable cleared", cnt_lo_q, alt_lo);
    cfg_we = 1; cfg_en = 1; step(); cfg_we = 0;
  endtask

  task automatic t_sat();
    logic [7:0] hi, lo, st;
    send_bytes(16400); close_frame(0, 5'd0, 0);
    read_entry(hi, lo, st);
    check("R1 saturated count", {hi, lo}, 16'h7FFF);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    step();
    t_reset();
    t_frames();
    t_overflow();
    t_full_swap();
    t_bypass();
    t_sat();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule